// File: doc/BRIEF.md
# SPI Master Serial Clock Divider

This block turns a peripheral clock into the serial clock of an SPI master. Software loads an 8-bit divide value through a small write port, and SCK runs at the peripheral clock frequency divided by that value, with equal high and low phases. SCK runs only while the block is in master mode and a transfer is active. A test-force input keeps it running at all times, whatever the mode or transfer state.

The divide value is legal only when it is even and at least 8. If master mode sees an illegal value, the block raises an invalid-setting flag and keeps SCK at its idle (low) level. A one-cycle edge strobe marks every divider-driven SCK transition, so the neighbouring shift logic knows when to sample and when to launch data.

Control is a three-state machine. The states are `ST_IDLE` (SCK low, divide counter cleared), `ST_RUN` (divide counter active) and `ST_FAULT` (illegal value in master mode with test-force off). Its transitions are:
- IDLE→RUN when a run request appears (test-force, or master mode with a transfer active).
- RUN→IDLE when the request drops.
- IDLE→FAULT and RUN→FAULT when the fault condition appears.
- FAULT→IDLE when the fault clears.

Top module: `sck_divider`

## Requirements
- R1: During and after reset, `sck` is 0, `sck_edge` is 0 and the divide register holds 0x00, so `div_invalid` reads 1 while `master_sel` is 1.
- R2: The divide register takes `cfg_wdata` on a clock edge where `cfg_we` is 1. While `cfg_we` is 0, changes on `cfg_wdata` have no effect.
- R3: `div_invalid` is 1 exactly when `master_sel` is 1 and the divide value is odd or below 8. It reflects a write in the cycle after the write edge. It is 0 in slave mode.
- R4: With `master_sel`=1, `xfer_active`=1, `test_force`=0 and a legal value N, `sck` changes level every N/2 clocks. The first change comes N/2+1 clock edges after the request is applied, and `sck` starts high.
- R5: With no run request, `sck` is held at 0 and the divide counter is cleared. After a request drops, `sck` is back at 0 within two clocks and produces no strobe. Each new request restarts the timing of R4.
- R6: With `master_sel`=1, `test_force`=0 and an illegal value, `sck` stays 0 and `sck_edge` never pulses, even while `xfer_active` is 1.
- R7: With `test_force`=1 and a legal value N, `sck` toggles every N/2 clocks regardless of `master_sel` and `xfer_active`.
- R8: With `test_force`=1 and an illegal value, `sck` toggles every 4 clocks, the minimum legal half period.
- R9: With `master_sel`=0 and `test_force`=0, `sck` stays 0 whatever the divide value and `xfer_active`.
- R10: `sck_edge` is 1 for exactly one clock, in the cycle in which `sck` shows a new level from the divider. The divider never changes `sck` without the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for the divide register |
| cfg_wdata | input | 8 | Divide value to load |
| master_sel | input | 1 | 1 selects master mode |
| xfer_active | input | 1 | 1 while a transfer is in progress |
| test_force | input | 1 | 1 forces SCK to run continuously |
| sck | output | 1 | Serial clock, idle low |
| sck_edge | output | 1 | One-cycle strobe on each divider SCK transition |
| div_invalid | output | 1 | Illegal divide value while in master mode |

## Verification
The hardest situation to reach is test-force combined with an illegal divide value. In that case the fault path must give way, and the divider must fall back to its minimum half period instead of using the programmed value. Reaching it requires writing an odd or small value and raising `test_force`, with `master_sel` either high or low. Directed trials use values 7 and 3 for this. Random trials draw small divide values so that illegal and legal settings occur about equally often against all eight combinations of the three control inputs.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } sck_state_e;

endpackage

// File: rtl/sckdiv_reg.sv
module sckdiv_reg #(
    parameter int CNT_W   = 8,
    parameter int MIN_DIV = 8,
    localparam int HALF_W = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic              valid_o,
    output logic [HALF_W-1:0] half_o
);

    localparam logic [CNT_W-1:0]  MIN_CNT  = CNT_W'(MIN_DIV);
    localparam logic [HALF_W-1:0] MIN_HALF = HALF_W'(MIN_DIV / 2);

    logic [CNT_W-1:0] count_q;
    logic             legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (we_i) begin
            count_q <= wdata_i;
        end
    end

    always_comb begin
        legal   = (count_q >= MIN_CNT) && !count_q[0];
        valid_o = legal;
        if (legal) begin
            half_o = count_q[CNT_W-1:1];
        end else begin
            half_o = MIN_HALF;
        end
    end

    assert_load_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> count_q == $past(wdata_i));

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(count_q));

endmodule

// File: rtl/sckdiv_fsm.sv
module sckdiv_fsm
    import sckdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req_i,
    input  logic fault_i,
    output logic run_en_o
);

    sck_state_e state_q;
    sck_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fault_i) begin
                    state_d = ST_FAULT;
                end else if (run_req_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (fault_i) begin
                    state_d = ST_FAULT;
                end else if (!run_req_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!fault_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        run_en_o = (state_q == ST_RUN);
    end

    assert_run_only_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(run_req_i) && !$past(fault_i)));

    assert_fault_entered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> (state_q == ST_FAULT));

endmodule

// File: rtl/sckdiv_toggle.sv
module sckdiv_toggle #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              sck_o,
    output logic              edge_o
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W:0]   cnt_next;
    logic              wrap;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + 1'b1;
        wrap     = cnt_next >= {1'b0, half_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sck_o  <= 1'b0;
            edge_o <= 1'b0;
        end else if (!run_en_i) begin
            cnt_q  <= '0;
            sck_o  <= 1'b0;
            edge_o <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sck_o  <= !sck_o;
            edge_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_next[HALF_W-1:0];
            edge_o <= 1'b0;
        end
    end

    assert_edge_marks_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (sck_o != $past(sck_o)));

    assert_edge_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (!sck_o && !edge_o && cnt_q == '0));

endmodule

// File: rtl/sck_divider.sv
module sck_divider #(
    parameter int CNT_W   = 8,
    parameter int MIN_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             master_sel,
    input  logic             xfer_active,
    input  logic             test_force,
    output logic             sck,
    output logic             sck_edge,
    output logic             div_invalid
);

    localparam int HALF_W = CNT_W - 1;

    logic              cnt_valid;
    logic [HALF_W-1:0] half_per;
    logic              run_req;
    logic              fault;
    logic              run_en;

    sckdiv_reg #(
        .CNT_W   (CNT_W),
        .MIN_DIV (MIN_DIV)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .valid_o (cnt_valid),
        .half_o  (half_per)
    );

    always_comb begin
        run_req     = test_force || (master_sel && xfer_active);
        fault       = master_sel && !cnt_valid && !test_force;
        div_invalid = master_sel && !cnt_valid;
    end

    sckdiv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req_i (run_req),
        .fault_i   (fault),
        .run_en_o  (run_en)
    );

    sckdiv_toggle #(
        .HALF_W (HALF_W)
    ) u_toggle (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en_i (run_en),
        .half_i   (half_per),
        .sck_o    (sck),
        .edge_o   (sck_edge)
    );

    assert_fault_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_invalid && !test_force) |-> ##2 !sck_edge);

    assert_slave_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && !test_force) |-> ##2 !sck_edge);

endmodule

// File: tb/sck_divider_bench.sv
module sck_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [7:0] cfg_wdata;
    logic       master_sel;
    logic       xfer_active;
    logic       test_force;
    logic       sck;
    logic       sck_edge;
    logic       div_invalid;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sck_divider u_sck_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .master_sel  (master_sel),
        .xfer_active (xfer_active),
        .test_force  (test_force),
        .sck         (sck),
        .sck_edge    (sck_edge),
        .div_invalid (div_invalid)
    );

    function automatic bit legal_div(input logic [7:0] v);
        return (v >= 8'd8) && !v[0];
    endfunction

    function automatic int exp_half(input logic [7:0] v, input bit m, input bit x, input bit t);
        if (t) return legal_div(v) ? int'(v) / 2 : 4;
        if (m && x && legal_div(v)) return int'(v) / 2;
        return 0;
    endfunction

    function automatic bit exp_flag(input logic [7:0] v, input bit m);
        return m && !legal_div(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiesce();
        @(negedge clk);
        master_sel  = 1'b0;
        xfer_active = 1'b0;
        test_force  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_count(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = ~v;
    endtask

    task automatic trial(input logic [7:0] v, input bit m, input bit x, input bit t,
                         input string req);
        int  h;
        int  n;
        int  first;
        int  last;
        int  edges;
        int  bad_gap;
        int  mism;
        logic prev;
        quiesce();
        check(sck == 1'b0, req, "sck idle before trial", int'(sck), 0);
        write_count(v);
        master_sel = m;
        #1;
        check(div_invalid == exp_flag(v, m), "R3", "div_invalid", int'(div_invalid),
              int'(exp_flag(v, m)));
        xfer_active = x;
        test_force  = t;
        h       = exp_half(v, m, x, t);
        n       = (h != 0) ? 6 * h + 2 : 40;
        first   = 0;
        last    = 0;
        edges   = 0;
        bad_gap = 0;
        mism    = 0;
        prev    = sck;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if ((sck != prev) != sck_edge) mism++;
            if (sck_edge) begin
                edges++;
                if (first == 0) begin
                    first = i;
                    if (sck != 1'b1) mism++;
                end else if (i - last != h) begin
                    bad_gap++;
                end
                last = i;
            end
            prev = sck;
        end
        check(mism == 0, "R10", "strobe/sck mismatches", mism, 0);
        if (h == 0) begin
            check(edges == 0 && sck == 1'b0, req, "strobes with no clock expected", edges, 0);
        end else begin
            check(first == h + 1, req, "first toggle cycle", first, h + 1);
            check(bad_gap == 0 && edges == 6, req, "toggle count at half period",
                  edges, 6);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n       = 1'b0;
        cfg_we      = 1'b0;
        cfg_wdata   = 8'd0;
        master_sel  = 1'b1;
        xfer_active = 1'b1;
        test_force  = 1'b0;
        repeat (3) @(negedge clk);
        check(sck == 1'b0 && sck_edge == 1'b0, "R1", "outputs in reset",
              int'({sck, sck_edge}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sck == 1'b0 && sck_edge == 1'b0, "R1", "outputs after reset",
              int'({sck, sck_edge}), 0);
        check(div_invalid == 1'b1, "R1", "flag for reset count 0", int'(div_invalid), 1);

        // R2: value on cfg_wdata without cfg_we is ignored
        quiesce();
        write_count(8'd16);
        cfg_wdata  = 8'd9;
        master_sel = 1'b1;
        repeat (3) @(negedge clk);
        check(div_invalid == 1'b0, "R2", "flag after ignored data", int'(div_invalid), 0);
        trial(8'd16, 1'b1, 1'b1, 1'b0, "R2");

        trial(8'd8,   1'b1, 1'b1, 1'b0, "R4");
        trial(8'd254, 1'b1, 1'b1, 1'b0, "R4");
        trial(8'd10,  1'b1, 1'b0, 1'b0, "R5");
        trial(8'd9,   1'b1, 1'b1, 1'b0, "R6");
        trial(8'd6,   1'b1, 1'b1, 1'b0, "R6");
        trial(8'd12,  1'b0, 1'b0, 1'b1, "R7");
        trial(8'd7,   1'b0, 1'b0, 1'b1, "R8");
        trial(8'd3,   1'b1, 1'b1, 1'b1, "R8");
        trial(8'd20,  1'b0, 1'b1, 1'b0, "R9");
        trial(8'd5,   1'b0, 1'b1, 1'b0, "R9");

        // R5: dropping the request mid-run returns sck low without strobes
        begin
            int strobes;
            quiesce();
            write_count(8'd8);
            master_sel  = 1'b1;
            xfer_active = 1'b1;
            repeat (7) @(negedge clk);
            xfer_active = 1'b0;
            repeat (2) @(negedge clk);
            check(sck == 1'b0, "R5", "sck after stop", int'(sck), 0);
            strobes = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (sck_edge || sck) strobes++;
            end
            check(strobes == 0, "R5", "activity after stop", strobes, 0);
        end

        for (int k = 0; k < 40; k++) begin
            logic [7:0] v;
            bit m;
            bit x;
            bit t;
            v = 8'($urandom_range(0, 40));
            m = 1'($urandom);
            x = 1'($urandom);
            t = 1'($urandom);
            if (t) trial(v, m, x, t, legal_div(v) ? "R7" : "R8");
            else if (!m) trial(v, m, x, t, "R9");
            else if (!legal_div(v)) trial(v, m, x, t, "R6");
            else if (x) trial(v, m, x, t, "R4");
            else trial(v, m, x, t, "R5");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule